// File: doc/BRIEF.md
# Bidirectional I/O port with peripheral takeover

This block is one general-purpose I/O port of a small controller. It has a configurable width, eight pins by default. Software reaches it through three registers on a simple register bus. The direction register sets, per pin, whether the pin is an input (bit 1) or driven (bit 0). The output latch holds the value driven on pins that software owns. The pin register returns the synchronised level seen on each pin. Writes to either the latch address or the pin address update the latch. The block does not model a tri-state pad. For every pin it produces a separate output value, an output-enable and a synchronised input.

Any pin can be taken over by an on-chip peripheral. A per-pin select hands the pin's output value to the peripheral. While that select is high, the peripheral can also ask for the pin to be driven. A separate per-pin force-input line ranks above everything else and turns the driver off. None of these overrides is ever stored in the direction register. A software read-modify-write of that register therefore sees only what software itself last wrote.

Register addresses on the 2-bit bus are: 0 for direction, 1 for the output latch, 2 for the pin level, and 3 unused. Read data is combinational from the address.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the direction register reads all ones, the output latch reads zero, and no pin's output-enable is high.
- R2: A write strobe with address 0 stores the write data in the direction register on that clock edge, and a read at address 0 returns the stored value.
- R3: A write strobe with address 1 or address 2 stores the write data in the output latch, and a read at address 1 returns the latch contents.
- R4: A read at address 2 and the peripheral data-in bus both return the pin inputs through a two-flop synchroniser. A pin change made between edges shows up after the second following rising edge and not after the first.
- R5: Address 3 reads as zero, and a write to address 3 changes neither the direction register nor the latch.
- R6: On a pin whose peripheral select and force-input are both low, the output value is the latch bit and the output-enable is the inverse of the direction bit.
- R7: On a pin whose peripheral select is high, the output value is the peripheral's data-out bit instead of the latch bit.
- R8: A pin is driven when its peripheral select and its peripheral output request are both high. The peripheral output request has no effect while the select is low.
- R9: A high force-input bit holds that pin's output-enable low, whatever the direction bit, select and output request are.
- R10: The peripheral select, output request and force-input lines never change the direction register. Reading address 0 returns the last value software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address (0 direction, 1 latch, 2 pin level, 3 unused) |
| bus_wdata | input | WIDTH | Write data |
| bus_we | input | 1 | Write strobe, one write per clock with it high |
| bus_rdata | output | WIDTH | Combinational read data for bus_addr |
| periph_sel | input | WIDTH | Per-pin peripheral select for the output value |
| periph_dout | input | WIDTH | Per-pin peripheral data-out |
| periph_oe | input | WIDTH | Per-pin peripheral drive request, honoured only with select |
| periph_force_in | input | WIDTH | Per-pin force-input, highest priority |
| periph_din | output | WIDTH | Synchronised pin levels for peripherals |
| pad_in | input | WIDTH | Raw pin levels |
| pad_out | output | WIDTH | Per-pin output value |
| pad_oe | output | WIDTH | Per-pin output-enable, 1 drives the pin |

## Verification
On every cycle the assertions check the override priority on each pin: force-input keeps the driver off, select together with the output request turns it on, and without either override the direction bit governs. They also check that the selected pin carries peripheral data, that register writes land one edge later, that the direction register never moves without a write to address 0, that address 3 reads zero, and that the synchronised input lags the pin by exactly two edges. Only the bench's scenarios can show the reset contents, the differing read values of addresses 1 and 2, writes through address 2, and whole pin patterns mixing all override kinds against hand-computed results.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_DIR   = 2'd0,
      REG_LATCH = 2'd1,
      REG_PIN   = 2'd2,
      REG_NONE  = 2'd3
   } gpio_reg_e;

endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter logic [WIDTH-1:0] DIR_RST = '1,
   parameter logic [WIDTH-1:0] LAT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic              we,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  rdata,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  lat_q
);

   gpio_reg_e sel_reg;
   logic      wr_dir;
   logic      wr_lat;

   assign sel_reg = gpio_reg_e'(addr);
   assign wr_dir  = we && (sel_reg == REG_DIR);
   assign wr_lat  = we && ((sel_reg == REG_LATCH) || (sel_reg == REG_PIN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_RST;
      end else if (wr_dir) begin
         dir_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= LAT_RST;
      end else if (wr_lat) begin
         lat_q <= wdata;
      end
   end

   always_comb begin
      unique case (sel_reg)
         REG_DIR:   rdata = dir_q;
         REG_LATCH: rdata = lat_q;
         REG_PIN:   rdata = pin_sync;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain[0] <= '0;
      end else begin
         chain[0] <= d;
      end
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] periph_sel,
   input  logic [WIDTH-1:0] periph_dout,
   input  logic [WIDTH-1:0] periph_oe,
   input  logic [WIDTH-1:0] periph_force_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);

   for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      always_comb begin
         pad_out[p] = periph_sel[p] ? periph_dout[p] : lat_q[p];
         if (periph_force_in[p]) begin
            pad_oe[p] = 1'b0;
         end else if (periph_sel[p] && periph_oe[p]) begin
            pad_oe[p] = 1'b1;
         end else begin
            pad_oe[p] = ~dir_q[p];
         end
      end
   end

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic              bus_we,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  periph_sel,
   input  logic [WIDTH-1:0]  periph_dout,
   input  logic [WIDTH-1:0]  periph_oe,
   input  logic [WIDTH-1:0]  periph_force_in,
   output logic [WIDTH-1:0]  periph_din,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_ovr_port: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_ovr_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] lat_q;
   logic [WIDTH-1:0] pin_sync;

   gpio_ovr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   gpio_ovr_regs #(.WIDTH(WIDTH)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .we       (bus_we),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata),
      .dir_q    (dir_q),
      .lat_q    (lat_q)
   );

   gpio_ovr_pinmux #(.WIDTH(WIDTH)) u_mux (
      .dir_q           (dir_q),
      .lat_q           (lat_q),
      .periph_sel      (periph_sel),
      .periph_dout     (periph_dout),
      .periph_oe       (periph_oe),
      .periph_force_in (periph_force_in),
      .pad_out         (pad_out),
      .pad_oe          (pad_oe)
   );

   assign periph_din = pin_sync;

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk
   import gpio_ovr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic              bus_we,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  periph_sel,
   input logic [WIDTH-1:0]  periph_dout,
   input logic [WIDTH-1:0]  periph_oe,
   input logic [WIDTH-1:0]  periph_force_in,
   input logic [WIDTH-1:0]  periph_din,
   input logic [WIDTH-1:0]  pad_in,
   input logic [WIDTH-1:0]  pad_out,
   input logic [WIDTH-1:0]  pad_oe,
   input logic [WIDTH-1:0]  dir_q,
   input logic [WIDTH-1:0]  lat_q
);

   logic [1:0] warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm <= '0;
      end else if (warm != 2'd2) begin
         warm <= warm + 2'd1;
      end
   end

   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 2'd0) |=> (dir_q == $past(bus_wdata))); // R2

   AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2)) |=> (lat_q == $past(bus_wdata))); // R3

   AST_PIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd2) |-> (bus_rdata == periph_din)); // R4

   if (SYNC_STAGES == 2) begin : g_sync2
      AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2'd2) |-> (periph_din == $past(pad_in, 2))); // R4
   end

   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R5

   AST_DIR_GOVERNS: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_oe ^ ~dir_q) | (pad_out ^ lat_q)) & ~periph_sel & ~periph_force_in) == '0); // R6

   AST_PERIPH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out ^ periph_dout) & periph_sel) == '0); // R7

   AST_PERIPH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_sel & periph_oe & ~periph_force_in & ~pad_oe) == '0); // R8

   AST_FORCE_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_force_in & pad_oe) == '0); // R9

   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == 2'd0) |=> $stable(dir_q)); // R10

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .bus_addr        (bus_addr),
   .bus_wdata       (bus_wdata),
   .bus_we          (bus_we),
   .bus_rdata       (bus_rdata),
   .periph_sel      (periph_sel),
   .periph_dout     (periph_dout),
   .periph_oe       (periph_oe),
   .periph_force_in (periph_force_in),
   .periph_din      (periph_din),
   .pad_in          (pad_in),
   .pad_out         (pad_out),
   .pad_oe          (pad_oe),
   .dir_q           (dir_q),
   .lat_q           (lat_q)
);

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic [W-1:0] bus_wdata = '0;
   logic         bus_we = 1'b0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] periph_sel = '0;
   logic [W-1:0] periph_dout = '0;
   logic [W-1:0] periph_oe = '0;
   logic [W-1:0] periph_force_in = '0;
   logic [W-1:0] periph_din;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpio_ovr_port #(.WIDTH(W)) u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .bus_addr        (bus_addr),
      .bus_wdata       (bus_wdata),
      .bus_we          (bus_we),
      .bus_rdata       (bus_rdata),
      .periph_sel      (periph_sel),
      .periph_dout     (periph_dout),
      .periph_oe       (periph_oe),
      .periph_force_in (periph_force_in),
      .periph_din      (periph_din),
      .pad_in          (pad_in),
      .pad_out         (pad_out),
      .pad_oe          (pad_oe)
   );

   // {dir, latch, sel, dout, oe, force_in, expected out, expected oe}
   localparam int NV = 6;
   localparam logic [63:0] VEC [NV] = '{
      {8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
      {8'hCF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h30},
      {8'hFF, 8'h0F, 8'hF0, 8'hAA, 8'h30, 8'h00, 8'hAF, 8'h30},
      {8'h00, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h81, 8'hF0, 8'h7E},
      {8'h55, 8'h33, 8'hFF, 8'h3C, 8'h0F, 8'hF0, 8'h3C, 8'h0F},
      {8'hAA, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h55}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents
      bus_read(2'd0, rd);
      check("R1 dir reset", rd, 8'hFF);
      bus_read(2'd1, rd);
      check("R1 latch reset", rd, 8'h00);
      check("R1 oe reset", pad_oe, 8'h00);

      // vector table: R2 R3 R6 R7 R8 R9 R10
      for (int i = 0; i < NV; i++) begin
         logic [63:0] v;
         v = VEC[i];
         bus_write(2'd0, v[63:56]);
         bus_write(2'd1, v[55:48]);
         @(negedge clk);
         periph_sel      = v[47:40];
         periph_dout     = v[39:32];
         periph_oe       = v[31:24];
         periph_force_in = v[23:16];
         #1;
         check("R6/R7 pad_out", pad_out, v[15:8]);
         check("R6/R8/R9 pad_oe", pad_oe, v[7:0]);
         bus_read(2'd0, rd);
         check("R2/R10 dir readback", rd, v[63:56]);
         bus_read(2'd1, rd);
         check("R3 latch readback", rd, v[55:48]);
      end
      @(negedge clk);
      periph_sel = '0; periph_dout = '0; periph_oe = '0; periph_force_in = '0;

      // R3 write through the pin address; R4 pin read differs from latch
      bus_write(2'd2, 8'h3C);
      bus_read(2'd1, rd);
      check("R3 latch via pin addr", rd, 8'h3C);
      bus_read(2'd2, rd);
      check("R4 pin read not latch", rd, 8'h00);

      // R4 synchroniser latency
      bus_addr = 2'd2;
      pad_in = 8'h5A;
      @(negedge clk);
      check("R4 one edge", bus_rdata, 8'h00);
      check("R4 din one edge", periph_din, 8'h00);
      @(negedge clk);
      check("R4 two edges", bus_rdata, 8'h5A);
      check("R4 din two edges", periph_din, 8'h5A);

      // R5 unused address
      bus_write(2'd0, 8'h12);
      bus_write(2'd3, 8'hAB);
      bus_read(2'd3, rd);
      check("R5 unused reads zero", rd, 8'h00);
      bus_read(2'd0, rd);
      check("R5 dir untouched", rd, 8'h12);
      bus_read(2'd1, rd);
      check("R5 latch untouched", rd, 8'h3C);

      // R10 overrides do not touch direction, R9 force-input with dir=0
      bus_write(2'd0, 8'h00);
      @(negedge clk);
      periph_sel = 8'hFF; periph_oe = 8'hFF; periph_force_in = 8'hFF;
      repeat (2) @(negedge clk);
      check("R9 all forced input", pad_oe, 8'h00);
      bus_read(2'd0, rd);
      check("R10 dir after overrides", rd, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule